// File: doc/BRIEF.md
# Cascadable Loadable Up/Down Binary Counter

This block is a synchronous 32-bit binary counter that can step up or down, be cleared at once or on a clock edge, be forced to all ones, or take a parallel value. Counting only happens when both a count enable and a carry-in are high. A direction input picks increment or decrement.

The counter is built from identical 8-bit slices. Each slice flags its terminal value through a combinational carry-out, and that carry-out is the carry-in of the slice above it. The chain therefore behaves as one wide counter. The lowest slice takes the top-level carry-in, and the highest slice gives the top-level carry-out, so several of these counters can themselves be chained.

Control inputs follow a fixed priority. The asynchronous clear wins over everything. Below it, in order, come preset, synchronous clear, load, and then gated counting.

Top module: `udc_cascade`

## Requirements
- R1: A high `clr_async` forces `count` to zero at once, without waiting for a clock edge, and holds it at zero whatever the other inputs do.
- R2: With `clr_async` low, a high `preset` makes every bit of `count` 1 at the next rising edge, whatever `sclr`, `load`, `en` and `cin` are.
- R3: With `clr_async` and `preset` low, a high `sclr` makes `count` zero at the next rising edge, even if `load` or counting is requested.
- R4: With `clr_async`, `preset` and `sclr` low, a high `load` copies `din` into `count` at the next rising edge, whatever `en`, `cin` and `up` are.
- R5: When no clear, preset or load is active and either `en` or `cin` is low, `count` keeps its value across the edge.
- R6: With `en` and `cin` both high and no higher-priority control, `up`=1 adds one and `up`=0 subtracts one at each rising edge. Counting wraps modulo 2^32: up from 0xFFFFFFFF gives 0, and down from 0 gives 0xFFFFFFFF.
- R7: `cout` is combinational. It equals `cin & en & up` while `count` is 0xFFFFFFFF, equals `cin & en & ~up` while `count` is 0, and is 0 for every other count value.
- R8: The four 8-bit slices chained through their carries give the same `count` as a single 32-bit counter at every edge, including borrows and carries that cross slice boundaries (for example, 0x000000FF plus one gives 0x00000100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clr_async | input | 1 | Active-high asynchronous clear to zero |
| preset | input | 1 | Active-high synchronous set to all ones |
| sclr | input | 1 | Active-high synchronous clear to zero |
| load | input | 1 | Active-high parallel load of `din` |
| din | input | 32 | Parallel load value |
| en | input | 1 | Count enable |
| cin | input | 1 | Carry-in of the lowest slice |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | 32 | Current count |
| cout | output | 1 | Combinational carry-out of the highest slice |

## Verification
Most assertions are switched off while `clr_async` is high. They expect every other input to be a settled 0 or 1 at each rising edge, and they expect the clear to be released away from an edge. The bench respects both: it changes inputs only on the falling clock edge, and it raises and drops the clear in the middle of the low phase. The random stimulus keeps preset, synchronous clear and load rare and the enable and carry-in mostly high, so that long count runs reach the slice boundaries. Directed loads near the terminal values add cases that the random stimulus would seldom produce.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_SETALL = 3'd1,
    OP_ZERO   = 3'd2,
    OP_LOAD   = 3'd3,
    OP_INC    = 3'd4,
    OP_DEC    = 3'd5
  } udc_op_e;

  // Fixed priority: set-all, sync zero, load, gated count, hold.
  function automatic udc_op_e udc_decode(input logic preset, input logic sclr,
                                         input logic load, input logic en,
                                         input logic cin, input logic up);
    if (preset)         return OP_SETALL;
    else if (sclr)      return OP_ZERO;
    else if (load)      return OP_LOAD;
    else if (en && cin) return up ? OP_INC : OP_DEC;
    else                return OP_HOLD;
  endfunction

endpackage

// File: rtl/udc_termdet.sv
module udc_termdet #(
  parameter int W = 8
) (
  input  logic [W-1:0] q,
  input  logic         cin,
  input  logic         en,
  input  logic         up,
  output logic         cout
);
  logic at_top;
  logic at_bot;

  always_comb begin
    at_top = &q;
    at_bot = ~|q;
    cout   = cin & en & (up ? at_top : at_bot);
  end
endmodule

// File: rtl/udc_slice.sv
module udc_slice
  import udc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_async,
  input  logic         preset,
  input  logic         sclr,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         cin,
  input  logic         up,
  output logic [W-1:0] q,
  output logic         cout
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  udc_op_e      op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic         upd;

  // next-state process
  always_comb begin
    op   = udc_decode(preset, sclr, load, en, cin, up);
    upd  = (op != OP_HOLD);
    case (op)
      OP_SETALL: q_nx = ALL_ONES;
      OP_ZERO:   q_nx = '0;
      OP_LOAD:   q_nx = d;
      OP_INC:    q_nx = q_r + ONE;
      OP_DEC:    q_nx = q_r - ONE;
      default:   q_nx = q_r;
    endcase
  end

  // register process with written-out clock enable
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)  q_r <= '0;
    else if (upd)   q_r <= q_nx;
  end

  assign q = q_r;

  udc_termdet #(.W(W)) term_i (
    .q    (q_r),
    .cin  (cin),
    .en   (en),
    .up   (up),
    .cout (cout)
  );

  AST_PRESET_ALL_ONES: assert property (@(posedge clk) disable iff (clr_async)
    preset |=> (q == ALL_ONES)); // R2
  AST_SCLR_TO_ZERO: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && sclr) |=> (q == '0)); // R3
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && load) |=> (q == $past(d))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && !load && !(en && cin)) |=> $stable(q)); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && !load && en && cin && up) |=> (q == $past(q) + ONE)); // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && !load && en && cin && !up) |=> (q == $past(q) - ONE)); // R6
  AST_CARRY_MIDRANGE: assert property (@(posedge clk) disable iff (clr_async)
    ((q != ALL_ONES) && (q != '0)) |-> !cout); // R7
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (clr_async)
    cout |-> (cin && en)); // R7
endmodule

// File: rtl/udc_cascade.sv
module udc_cascade #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 4
) (
  input  logic                          clk,
  input  logic                          clr_async,
  input  logic                          preset,
  input  logic                          sclr,
  input  logic                          load,
  input  logic [SLICE_W*NUM_SLICES-1:0] din,
  input  logic                          en,
  input  logic                          cin,
  input  logic                          up,
  output logic [SLICE_W*NUM_SLICES-1:0] count,
  output logic                          cout
);
  localparam int CNT_W = SLICE_W * NUM_SLICES;

  logic [NUM_SLICES:0] carry;

  assign carry[0] = cin;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    udc_slice #(.W(SLICE_W)) slice_i (
      .clk       (clk),
      .clr_async (clr_async),
      .preset    (preset),
      .sclr      (sclr),
      .load      (load),
      .d         (din[k*SLICE_W +: SLICE_W]),
      .en        (en),
      .cin       (carry[k]),
      .up        (up),
      .q         (count[k*SLICE_W +: SLICE_W]),
      .cout      (carry[k+1])
    );
  end

  assign cout = carry[NUM_SLICES];

  AST_ASYNC_ZERO: assert property (@(posedge clk)
    clr_async |-> (count == '0)); // R1
  AST_WIDE_INC: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && !load && en && cin && up) |=>
      (count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1})); // R8
  AST_WIDE_DEC: assert property (@(posedge clk) disable iff (clr_async)
    (!preset && !sclr && !load && en && cin && !up) |=>
      (count == $past(count) - {{(CNT_W-1){1'b0}}, 1'b1})); // R8
  AST_TOP_CARRY_TERMINAL: assert property (@(posedge clk) disable iff (clr_async)
    cout |-> ((up && count == {CNT_W{1'b1}}) || (!up && count == '0))); // R7
endmodule

// File: tb/udc_cascade_tb_top.sv
module udc_cascade_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         clr_async, preset, sclr, load, en, cin, up;
  logic [W-1:0] din;
  logic [W-1:0] count;
  logic         cout;

  logic [W-1:0] model;
  int           n_checks = 0;
  int           n_fail   = 0;

  always #4 clk = ~clk;

  udc_cascade dut_i (
    .clk(clk), .clr_async(clr_async), .preset(preset), .sclr(sclr),
    .load(load), .din(din), .en(en), .cin(cin), .up(up),
    .count(count), .cout(cout)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] q,
      input logic p, input logic s, input logic l, input logic [W-1:0] d,
      input logic e, input logic c, input logic u);
    if (p)          return '1;
    else if (s)     return '0;
    else if (l)     return d;
    else if (e && c) return u ? q + 32'd1 : q - 32'd1;
    else            return q;
  endfunction

  function automatic logic ref_cout(input logic [W-1:0] q, input logic e,
                                    input logic c, input logic u);
    if (q == '1)      return c & e & u;
    else if (q == '0) return c & e & ~u;
    else              return 1'b0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic p, input logic s, input logic l,
                       input logic [W-1:0] d, input logic e, input logic c,
                       input logic u, input string req);
    @(negedge clk);
    preset = p; sclr = s; load = l; din = d; en = e; cin = c; up = u;
    #1;
    check("R7 cout", {31'd0, cout}, {31'd0, ref_cout(model, e, c, u)});
    @(posedge clk);
    model = ref_next(model, p, s, l, d, e, c, u);
    #1;
    check(req, count, model);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clr_async = 1'b1; preset = 0; sclr = 0; load = 0; en = 0; cin = 0; up = 1;
    din = '0; model = '0;
    #1;
    check("R1 reset state", count, '0);
    check("R7 cout in reset", {31'd0, cout}, 32'd0);
    @(negedge clk); @(negedge clk);
    #2 clr_async = 1'b0;

    // R4 load, R6 wrap up, R7 carry at top terminal
    apply(0, 0, 1, 32'hFFFF_FFFE, 1, 1, 1, "R4 load");
    apply(0, 0, 0, 32'h0, 1, 1, 1, "R6 up to all ones");
    apply(0, 0, 0, 32'h0, 1, 1, 1, "R6 wrap up to zero");
    // R6 wrap down, R7 at bottom
    apply(0, 0, 0, 32'h0, 1, 1, 0, "R6 wrap down to ones");
    // R8 carry across slice boundaries
    apply(0, 0, 1, 32'h0000_00FF, 0, 0, 1, "R4 load boundary");
    apply(0, 0, 0, 32'h0, 1, 1, 1, "R8 carry 8->9");
    apply(0, 0, 1, 32'h00FF_FFFF, 0, 0, 1, "R4 load boundary");
    apply(0, 0, 0, 32'h0, 1, 1, 1, "R8 carry 24->25");
    apply(0, 0, 0, 32'h0, 1, 1, 0, "R8 borrow 24->23");
    apply(0, 0, 1, 32'h0001_0000, 0, 0, 0, "R4 load boundary");
    apply(0, 0, 0, 32'h0, 1, 1, 0, "R8 borrow 16");
    // R5 hold with en or cin low
    apply(0, 0, 0, 32'h0, 0, 1, 1, "R5 hold en low");
    apply(0, 0, 0, 32'h0, 1, 0, 0, "R5 hold cin low");
    // priorities
    apply(1, 1, 1, 32'h1234_5678, 1, 1, 0, "R2 preset over all");
    apply(0, 1, 1, 32'h1234_5678, 1, 1, 1, "R3 sclr over load");
    apply(0, 0, 1, 32'hA5A5_5A5A, 1, 1, 1, "R4 load over count");
    apply(0, 0, 1, 32'h0000_0000, 0, 1, 1, "R4 load zero");

    // R1 async clear mid-cycle with preset pending
    @(negedge clk);
    preset = 1'b1;
    #1 clr_async = 1'b1;
    #1;
    check("R1 async clear immediate", count, '0);
    @(posedge clk); #1;
    check("R1 clear overrides preset", count, '0);
    @(negedge clk);
    preset = 1'b0;
    #2 clr_async = 1'b0;
    model = '0;

    // constrained random, R8 equivalence against 32-bit model
    for (int i = 0; i < 3000; i++) begin
      logic p, s, l, e, c, u;
      logic [W-1:0] d;
      p = ($urandom_range(0, 31) == 0);
      s = ($urandom_range(0, 31) == 0);
      l = ($urandom_range(0, 15) == 0);
      e = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 7) != 0);
      u = ($urandom_range(0, 63) < 40) ? 1'b1 : 1'b0;
      case ($urandom_range(0, 3))
        0:       d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
        1:       d = 32'($urandom_range(0, 15));
        2:       d = {8'($urandom), 24'hFFFF_F0} | 32'($urandom_range(0, 15));
        default: d = $urandom;
      endcase
      apply(p, s, l, d, e, c, u, "R8 random equivalence");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule